// File: doc/BRIEF.md
# Virtual Lane Receive Buffer with Credit Accounting

This block is the receive store of one virtual lane on a packet link, together with the credit bookkeeping that governs traffic on that lane. Incoming bytes are written at a speculative position in a circular byte store while an external integrity checker examines the packet. When the checker gives its verdict, the packet is either made visible to the reader in one step or dropped in one step. A byte-wide read port lets the next layer drain accepted packets in arrival order.

Credits are counted in 64-byte blocks on 12-bit counters that wrap. On the receive side the block keeps an adjusted count of received blocks. A flow-control packet from the peer reloads this count, and each accepted data packet advances it. The block advertises a credit limit equal to that count plus the free blocks of the store. On the transmit side it keeps the number of blocks sent. Against the last limit heard from the peer, it says whether a pending packet of a given size may go out now. A parameter turns the lane into the management lane, which sends without regard to credit.

Top module: `vlane_credit_buf`

## Requirements
- R1: After reset, `rd_empty` is 1, `overrun_err` is 0, `sent_total` is 0, and `adv_limit` equals the number of free 64-byte blocks of the empty store (16 for the default 1024-byte depth).
- R2: Bytes written with `in_vld` are not visible to the reader before a good verdict: `rd_empty` stays 1 and `adv_limit` is unchanged while a packet is only speculatively stored.
- R3: A pulse on `verdict_ok` makes the whole pending packet readable. `rd_byte` shows the oldest committed byte, and each `rd_take` on a non-empty store advances to the next byte, in write order across packets.
- R4: A pulse on `verdict_bad` discards the pending packet. Its bytes are never read, and the next accepted packet follows the previously committed bytes directly.
- R5: A byte offered while the store holds DEPTH_BYTES bytes (committed plus pending) is dropped, and `overrun_err` is 1 for the cycle after that write. A later `verdict_ok` for that packet then discards it like `verdict_bad`.
- R6: A pulse on `fc_rcv` loads the adjusted received-block count with `fc_peer_sent`. Each accepted packet of L bytes then adds ceil(L/64), modulo 4096.
- R7: `adv_limit` = (adjusted received-block count + min(floor(free bytes/64), 2048)) mod 4096, where the free bytes are DEPTH_BYTES minus the committed, unread bytes. Reading bytes raises it.
- R8: On a data lane, `tx_allow` is 1 exactly when ((CL − (`sent_total` + `tx_size`)) mod 4096) ≤ 2048, where CL is the `fc_peer_limit` taken at the last `fc_rcv` (0 after reset).
- R9: A pulse on `tx_done` adds `tx_size` to `sent_total`, modulo 4096.
- R10: `rd_take` while `rd_empty` is 1 has no effect: the next committed byte is still the first one read.
- R11: With MGMT_LANE = 1, `tx_allow` is always 1, whatever the credit limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (link initialisation) |
| in_vld | input | 1 | Incoming byte valid |
| in_byte | input | DATA_W | Incoming byte, stored at the speculative pointer |
| verdict_ok | input | 1 | Pending packet is good: commit it |
| verdict_bad | input | 1 | Pending packet is bad: discard it |
| overrun_err | output | 1 | A byte was dropped for lack of room in the previous cycle |
| rd_take | input | 1 | Consume the byte shown on `rd_byte` |
| rd_byte | output | DATA_W | Oldest committed byte |
| rd_empty | output | 1 | No committed byte is waiting |
| fc_rcv | input | 1 | Flow-control packet received from the peer |
| fc_peer_sent | input | CW | Peer's blocks-sent value from that packet |
| fc_peer_limit | input | CW | Peer's credit limit from that packet |
| adv_limit | output | CW | Credit limit to put in the next outgoing flow packet |
| tx_size | input | CW | Size in blocks of the pending outgoing packet |
| tx_done | input | 1 | Pending packet was sent |
| tx_allow | output | 1 | Pending packet may be sent now |
| sent_total | output | CW | Blocks sent since link initialisation |

## Verification
The checks assume that `verdict_ok` and `verdict_bad` never pulse together, that no byte is offered in a verdict cycle, and that every verdict refers to the bytes written since the previous verdict. The bench writes each packet as a run of bytes followed by a separate verdict cycle. It never drives both verdict lines at once, and it keeps flow-control pulses away from verdict cycles. Under these conditions it can predict commits, credits and overrun pulses with a plain byte-count model.

// File: rtl/vlcb_pkg.sv
package vlcb_pkg;
   // width of every credit counter; all arithmetic wraps at this width
   localparam int CREDIT_W   = 12;
   // one credit block is 2**BLK_SHIFT bytes
   localparam int BLK_SHIFT  = 6;
   localparam int BLK_BYTES  = 1 << BLK_SHIFT;
   // ceiling on the free-block term of the advertised limit
   localparam int ADV_CAP    = 2048;

   function automatic int half_range(input int w);
      return 1 << (w - 1);
   endfunction
endpackage

// File: rtl/vlcb_store.sv
module vlcb_store #(
   parameter int DEPTH = 1024,
   parameter int DW    = 8,
   parameter int PW    = 11,
   parameter int CW    = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   input  logic [DW-1:0] in_byte,
   input  logic          verdict_ok,
   input  logic          verdict_bad,
   input  logic          rd_take,
   output logic [DW-1:0] rd_byte,
   output logic          rd_empty,
   output logic          overrun_err,
   output logic [PW-1:0] rd_ptr,
   output logic [PW-1:0] wc_ptr,
   output logic [PW-1:0] sp_ptr,
   output logic          commit_fire,
   output logic [CW-1:0] commit_blocks
);
   import vlcb_pkg::*;
   localparam int AW = PW - 1;

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] rd_q, wc_q, sp_q;
   logic          ovf_q, err_q;
   logic          verdict, full, take_ok, drop, rd_go;
   logic [PW-1:0] occ, pend;
   logic [PW:0]   pend_ext, blk;

   always_comb begin
      verdict  = verdict_ok | verdict_bad;
      occ      = sp_q - rd_q;
      full     = (occ == PW'(DEPTH));
      take_ok  = in_vld & ~verdict & ~full;
      // R5: byte offered with no room left
      drop     = in_vld & ~verdict & full;
      // R10: a take on an empty store does nothing
      rd_go    = rd_take & (rd_q != wc_q);
      pend     = sp_q - wc_q;
      pend_ext = {1'b0, pend} + (PW+1)'(BLK_BYTES - 1);
      blk      = pend_ext >> BLK_SHIFT;
   end

   // R5: a packet that lost a byte is never committed
   assign commit_fire   = verdict_ok & ~ovf_q;
   assign commit_blocks = CW'(blk);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wc_q  <= '0;
         sp_q  <= '0;
         ovf_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         err_q <= drop;
         if (rd_go)
            rd_q <= rd_q + 1'b1;
         if (commit_fire) begin
            // R3: pending bytes become visible at once
            wc_q  <= sp_q;
            ovf_q <= 1'b0;
         end else if (verdict) begin
            // R4: roll the speculative pointer back
            sp_q  <= wc_q;
            ovf_q <= 1'b0;
         end else begin
            if (take_ok)
               sp_q <= sp_q + 1'b1;
            if (drop)
               ovf_q <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (take_ok)
         mem[sp_q[AW-1:0]] <= in_byte;
   end

   assign rd_byte     = mem[rd_q[AW-1:0]];
   // R2: emptiness is judged against the committed pointer only
   assign rd_empty    = (rd_q == wc_q);
   assign overrun_err = err_q;
   assign rd_ptr      = rd_q;
   assign wc_ptr      = wc_q;
   assign sp_ptr      = sp_q;
endmodule

// File: rtl/vlcb_rx_credit.sv
module vlcb_rx_credit #(
   parameter int DEPTH = 1024,
   parameter int PW    = 11,
   parameter int CW    = 12,
   parameter int CAP   = 2048
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fc_rcv,
   input  logic [CW-1:0] fc_peer_sent,
   input  logic          commit_fire,
   input  logic [CW-1:0] commit_blocks,
   input  logic [PW-1:0] rd_ptr,
   input  logic [PW-1:0] wc_ptr,
   output logic [CW-1:0] adv_limit
);
   import vlcb_pkg::*;

   logic [CW-1:0] abr_q, abr_base, abr_d, free_term;
   logic [PW-1:0] used, free_b, free_blk;

   always_comb begin
      // R6: flow packet reloads, accepted packet advances
      abr_base = fc_rcv ? fc_peer_sent : abr_q;
      abr_d    = abr_base + (commit_fire ? commit_blocks : '0);
      // R7: free space counts committed, unread bytes only
      used     = wc_ptr - rd_ptr;
      free_b   = PW'(DEPTH) - used;
      free_blk = free_b >> BLK_SHIFT;
      if (int'(free_blk) > CAP)
         free_term = CW'(CAP);
      else
         free_term = CW'(free_blk);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         abr_q <= '0;
      else
         abr_q <= abr_d;
   end

   assign adv_limit = abr_q + free_term;
endmodule

// File: rtl/vlcb_tx_gate.sv
module vlcb_tx_gate #(
   parameter int CW     = 12,
   parameter bit EXEMPT = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fc_rcv,
   input  logic [CW-1:0] fc_peer_limit,
   input  logic [CW-1:0] tx_size,
   input  logic          tx_done,
   output logic          tx_allow,
   output logic [CW-1:0] sent_total
);
   import vlcb_pkg::*;
   localparam int HALF = half_range(CW);

   logic [CW-1:0] sent_q;

   // R9: blocks sent since link initialisation, wrapping
   always_ff @(posedge clk) begin
      if (!rst_n)
         sent_q <= '0;
      else if (tx_done)
         sent_q <= sent_q + tx_size;
   end
   assign sent_total = sent_q;

   generate
      if (EXEMPT) begin : g_mgmt
         // R11: management traffic ignores credit
         logic unused_in;
         assign unused_in = fc_rcv ^ (^fc_peer_limit);
         assign tx_allow  = 1'b1;
      end else begin : g_data
         logic [CW-1:0] lim_q, need, gap;
         always_ff @(posedge clk) begin
            if (!rst_n)
               lim_q <= '0;
            else if (fc_rcv)
               lim_q <= fc_peer_limit;
         end
         // R8: modular distance to the peer's limit
         assign need     = sent_q + tx_size;
         assign gap      = lim_q - need;
         assign tx_allow = (gap <= CW'(HALF));
      end
   endgenerate
endmodule

// File: rtl/vlane_credit_buf.sv
module vlane_credit_buf #(
   parameter int DEPTH_BYTES = 1024,
   parameter int DATA_W      = 8,
   parameter int CW          = vlcb_pkg::CREDIT_W,
   parameter int ADV_CAP     = vlcb_pkg::ADV_CAP,
   parameter bit MGMT_LANE   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [DATA_W-1:0] in_byte,
   input  logic              verdict_ok,
   input  logic              verdict_bad,
   output logic              overrun_err,
   input  logic              rd_take,
   output logic [DATA_W-1:0] rd_byte,
   output logic              rd_empty,
   input  logic              fc_rcv,
   input  logic [CW-1:0]     fc_peer_sent,
   input  logic [CW-1:0]     fc_peer_limit,
   output logic [CW-1:0]     adv_limit,
   input  logic [CW-1:0]     tx_size,
   input  logic              tx_done,
   output logic              tx_allow,
   output logic [CW-1:0]     sent_total
);
   import vlcb_pkg::*;
   localparam int AW = $clog2(DEPTH_BYTES);
   localparam int PW = AW + 1;

   generate
      if ((DEPTH_BYTES % BLK_BYTES) != 0) begin : g_err_blk
         $error("DEPTH_BYTES must be a whole number of credit blocks");
      end
      if ((DEPTH_BYTES & (DEPTH_BYTES - 1)) != 0) begin : g_err_pow2
         $error("DEPTH_BYTES must be a power of two");
      end
      if ((DEPTH_BYTES / BLK_BYTES) >= (1 << CW)) begin : g_err_cw
         $error("credit width too small for the store depth");
      end
      if (ADV_CAP > half_range(CW)) begin : g_err_cap
         $error("ADV_CAP must not exceed half the credit range");
      end
   endgenerate

   logic [PW-1:0] rd_ptr, wc_ptr, sp_ptr;
   logic          commit_fire;
   logic [CW-1:0] commit_blocks;

   vlcb_store #(
      .DEPTH(DEPTH_BYTES), .DW(DATA_W), .PW(PW), .CW(CW)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .in_vld(in_vld), .in_byte(in_byte),
      .verdict_ok(verdict_ok), .verdict_bad(verdict_bad),
      .rd_take(rd_take), .rd_byte(rd_byte), .rd_empty(rd_empty),
      .overrun_err(overrun_err),
      .rd_ptr(rd_ptr), .wc_ptr(wc_ptr), .sp_ptr(sp_ptr),
      .commit_fire(commit_fire), .commit_blocks(commit_blocks)
   );

   vlcb_rx_credit #(
      .DEPTH(DEPTH_BYTES), .PW(PW), .CW(CW), .CAP(ADV_CAP)
   ) u_rx (
      .clk(clk), .rst_n(rst_n),
      .fc_rcv(fc_rcv), .fc_peer_sent(fc_peer_sent),
      .commit_fire(commit_fire), .commit_blocks(commit_blocks),
      .rd_ptr(rd_ptr), .wc_ptr(wc_ptr),
      .adv_limit(adv_limit)
   );

   vlcb_tx_gate #(
      .CW(CW), .EXEMPT(MGMT_LANE)
   ) u_tx (
      .clk(clk), .rst_n(rst_n),
      .fc_rcv(fc_rcv), .fc_peer_limit(fc_peer_limit),
      .tx_size(tx_size), .tx_done(tx_done),
      .tx_allow(tx_allow), .sent_total(sent_total)
   );
endmodule

// File: rtl/vlcb_chk.sv
module vlcb_chk #(
   parameter int DEPTH = 1024,
   parameter int PW    = 11,
   parameter int CW    = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_vld,
   input logic          verdict_ok,
   input logic          verdict_bad,
   input logic          rd_take,
   input logic          rd_empty,
   input logic          overrun_err,
   input logic          tx_done,
   input logic [CW-1:0] tx_size,
   input logic [CW-1:0] sent_total,
   input logic [PW-1:0] rd_ptr,
   input logic [PW-1:0] wc_ptr,
   input logic [PW-1:0] sp_ptr
);
   logic [PW-1:0] occ;
   assign occ = sp_ptr - rd_ptr;

   // R2
   commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !verdict_ok |=> $stable(wc_ptr));

   // R3
   read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_take && !rd_empty) |=> (rd_ptr == $past(rd_ptr) + 1'b1));

   // R4
   rollback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      verdict_bad |=> (sp_ptr == wc_ptr));

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(occ) <= DEPTH);

   // R5
   drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !verdict_ok && !verdict_bad && int'(occ) == DEPTH) |=> overrun_err);

   // R9
   sent_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |=> (sent_total == $past(sent_total + tx_size)));

   // R10
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_take && rd_empty) |=> $stable(rd_ptr));
endmodule

bind vlane_credit_buf vlcb_chk #(
   .DEPTH(DEPTH_BYTES), .PW(PW), .CW(CW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
   .verdict_ok(verdict_ok), .verdict_bad(verdict_bad),
   .rd_take(rd_take), .rd_empty(rd_empty), .overrun_err(overrun_err),
   .tx_done(tx_done), .tx_size(tx_size), .sent_total(sent_total),
   .rd_ptr(rd_ptr), .wc_ptr(wc_ptr), .sp_ptr(sp_ptr)
);

// File: tb/sim_vlane_credit_buf.sv
module sim_vlane_credit_buf;
   localparam int DEPTH = 1024;
   localparam int CW    = 12;

   logic clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic          rst_n, in_vld, verdict_ok, verdict_bad, rd_take;
   logic [7:0]    in_byte, rd_byte;
   logic          rd_empty, overrun_err, fc_rcv, tx_done, tx_allow;
   logic [CW-1:0] fc_peer_sent, fc_peer_limit, adv_limit, tx_size, sent_total;

   logic          m_ovf, m_empty, m_allow;
   logic [7:0]    m_byte;
   logic [CW-1:0] m_adv, m_sent, m_size;

   vlane_credit_buf #(.DEPTH_BYTES(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_byte(in_byte),
      .verdict_ok(verdict_ok), .verdict_bad(verdict_bad), .overrun_err(overrun_err),
      .rd_take(rd_take), .rd_byte(rd_byte), .rd_empty(rd_empty),
      .fc_rcv(fc_rcv), .fc_peer_sent(fc_peer_sent), .fc_peer_limit(fc_peer_limit),
      .adv_limit(adv_limit), .tx_size(tx_size), .tx_done(tx_done),
      .tx_allow(tx_allow), .sent_total(sent_total)
   );

   // management-lane variant
   vlane_credit_buf #(.DEPTH_BYTES(128), .MGMT_LANE(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .in_vld(1'b0), .in_byte(8'h00),
      .verdict_ok(1'b0), .verdict_bad(1'b0), .overrun_err(m_ovf),
      .rd_take(1'b0), .rd_byte(m_byte), .rd_empty(m_empty),
      .fc_rcv(1'b0), .fc_peer_sent('0), .fc_peer_limit('0),
      .adv_limit(m_adv), .tx_size(m_size), .tx_done(1'b0),
      .tx_allow(m_allow), .sent_total(m_sent)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [7:0] exp_q [$];
   int occ_m  = 0;
   int abr_m  = 0;
   int sent_m = 0;
   int lim_m  = 0;
   event rd_evt;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int adv_exp();
      int fb = (DEPTH - occ_m) / 64;
      if (fb > 2048) fb = 2048;
      return (abr_m + fb) % 4096;
   endfunction

   function automatic int mod12(input int v);
      return ((v % 4096) + 4096) % 4096;
   endfunction

   // driver: writes a packet, gives the verdict, pushes expected bytes
   task automatic send_pkt(input int len, input int seed, input bit good, output int ovf_cnt);
      logic [7:0] pkt [$];
      ovf_cnt = 0;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (overrun_err) ovf_cnt++;
         in_vld  = 1'b1;
         in_byte = 8'(seed + i * 7);
         if (occ_m + i < DEPTH) pkt.push_back(in_byte);
      end
      @(negedge clk);
      if (overrun_err) ovf_cnt++;
      in_vld = 1'b0;
      if (occ_m == 0) chk("R2 speculative bytes hidden: rd_empty", int'(rd_empty), 1);
      chk("R2 speculative bytes leave adv_limit alone", int'(adv_limit), adv_exp());
      if (good) verdict_ok = 1'b1; else verdict_bad = 1'b1;
      @(negedge clk);
      verdict_ok  = 1'b0;
      verdict_bad = 1'b0;
      if (good && occ_m + len <= DEPTH) begin
         foreach (pkt[k]) exp_q.push_back(pkt[k]);
         occ_m += len;
         abr_m  = (abr_m + (len + 63) / 64) % 4096;
      end
   endtask

   task automatic read_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rd_take = 1'b1;
         #1 -> rd_evt;
      end
      @(negedge clk);
      rd_take = 1'b0;
   endtask

   // monitor: pops the scoreboard for every take
   always @(rd_evt) begin
      logic [7:0] e;
      if (exp_q.size() == 0) begin
         chk("R10 take on empty store: rd_empty", int'(rd_empty), 1);
      end else begin
         e = exp_q.pop_front();
         chk("R3 read byte order", int'(rd_byte), int'(e));
         occ_m--;
      end
   end

   task automatic fc_pkt(input int sent, input int lim);
      @(negedge clk);
      fc_rcv        = 1'b1;
      fc_peer_sent  = CW'(sent);
      fc_peer_limit = CW'(lim);
      @(negedge clk);
      fc_rcv = 1'b0;
      abr_m  = sent;
      lim_m  = lim;
   endtask

   task automatic tx_try(input int s);
      int gap;
      @(negedge clk);
      tx_size = CW'(s);
      #1;
      gap = mod12(lim_m - sent_m - s);
      chk("R8 send permission", int'(tx_allow), (gap <= 2048) ? 1 : 0);
   endtask

   task automatic tx_send(input int s);
      @(negedge clk);
      tx_size = CW'(s);
      tx_done = 1'b1;
      @(negedge clk);
      tx_done = 1'b0;
      sent_m  = mod12(sent_m + s);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int ovf;
      rst_n = 1'b0; in_vld = 1'b0; in_byte = '0; verdict_ok = 1'b0; verdict_bad = 1'b0;
      rd_take = 1'b0; fc_rcv = 1'b0; fc_peer_sent = '0; fc_peer_limit = '0;
      tx_size = '0; tx_done = 1'b0; m_size = CW'(5);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 rd_empty after reset", int'(rd_empty), 1);
      chk("R1 overrun_err after reset", int'(overrun_err), 0);
      chk("R1 sent_total after reset", int'(sent_total), 0);
      chk("R1 adv_limit after reset", int'(adv_limit), 16);

      // R3 good packet, R4 bad packet, then another good one
      send_pkt(100, 1, 1'b1, ovf);
      chk("R3 committed packet visible", int'(rd_empty), 0);
      chk("R6 accepted packet adds ceil blocks", int'(adv_limit), adv_exp());
      send_pkt(70, 50, 1'b0, ovf);
      chk("R4 discarded packet costs no credit", int'(adv_limit), adv_exp());
      send_pkt(5, 200, 1'b1, ovf);
      read_n(105);
      chk("R4 store empty after draining", int'(rd_empty), 1);
      chk("R7 reading frees credit", int'(adv_limit), adv_exp());

      // R10 takes on an empty store are ignored
      read_n(2);
      send_pkt(3, 90, 1'b1, ovf);
      read_n(3);

      // R6 flow packet reload and wrap of R7
      fc_pkt(4090, 100);
      chk("R6 reload from peer blocks-sent (wraps)", int'(adv_limit), adv_exp());
      send_pkt(10, 33, 1'b1, ovf);
      chk("R6 increment after reload", int'(adv_limit), adv_exp());
      read_n(10);
      chk("R7 limit after drain", int'(adv_limit), adv_exp());

      // R8 / R9 transmit gate
      tx_try(50);
      tx_try(101);
      tx_send(60);
      chk("R9 blocks sent total", int'(sent_total), sent_m);
      tx_try(40);
      tx_try(41);
      fc_pkt(5, 2118);
      tx_try(10);
      tx_try(9);
      tx_send(4000);
      tx_send(100);
      chk("R9 blocks sent total wraps", int'(sent_total), 64);

      // R5 exact fill is accepted, overfill is rejected
      send_pkt(1024, 7, 1'b1, ovf);
      chk("R5 no drop when packet fits exactly", ovf, 0);
      chk("R7 full store advertises no free blocks", int'(adv_limit), adv_exp());
      read_n(1024);
      send_pkt(1025, 11, 1'b1, ovf);
      chk("R5 overrun_err pulses once", ovf, 1);
      chk("R5 overrun packet not committed", int'(rd_empty), 1);
      chk("R5 overrun packet costs no credit", int'(adv_limit), adv_exp());
      send_pkt(2, 77, 1'b1, ovf);
      read_n(2);
      chk("R3 scoreboard drained", exp_q.size(), 0);

      // R11 management lane always may send
      @(negedge clk);
      chk("R11 management lane tx_allow", int'(m_allow), 1);

      finish_run();
   end
endmodule